// File: doc/BRIEF.md
# Second-Driven Calendar Counter with Deferred Register Writes

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day, month, year offset, leap flag) in two packed registers. A single-cycle `sec_tick` pulse advances the count by one second. Carries run from seconds up through years, and a time and date that roll over together change on the same tick.

Software writes to the time or date register do not take effect at once. The written word is held in a pending slot, and a per-register busy bit in the control word reads 1 until the next second tick commits it. On that tick the pending value replaces the counted value. Software polls the busy bits before and after each write. Reads are combinational on the shared address.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, time reads 00:00:00, date reads day 1, month 1, year offset 0, leap flag 0, and the control word reads zero.
- R2: Register map. Control is at 0x00, date at 0x10 and time at 0x14; any other address reads 0. Time fields are seconds [5:0], minutes [13:8] and hours [20:16]. Date fields are day [4:0], month [11:8], year offset [21:16] and leap flag [22]. Control bit 8 is the time-busy flag, bit 7 the date-busy flag, and bit 9 always reads 0.
- R3: On a tick with no pending time write, seconds advance by one. 59 seconds wrap to 0 and carry into minutes, 59 minutes wrap and carry into hours, and hour 23 wraps to 0 and carries into the day.
- R4: A time write sets control bit 8 from the next cycle on. Until the commit, the time register keeps its counted value.
- R5: A date write sets control bit 7 from the next cycle on. Until the commit, the date register keeps its counted value.
- R6: On a tick with a write pending, the written fields replace the register without incrementing, and the matching busy bit reads 0 afterwards.
- R7: A write that arrives in the same cycle as a tick is not committed by that tick. The tick counts normally, the busy bit stays set, and the next tick commits the write.
- R8: The last day of a month rolls to day 1 of the next month. Months 4, 6, 9 and 11 have 30 days and the other months have 31, except February. February has 29 days when the leap flag is 1 and 28 when it is 0.
- R9: Month 12 rolls to month 1 and increments the year offset, with 63 wrapping to 0. On that roll the leap flag becomes 1 exactly when (new offset + 1970) is divisible by 4.
- R10: A carry into the date happens on the same tick as the time rollover. If a date write is pending on that tick, the date takes the written value instead. If a time write is pending, no carry reaches the date.
- R11: Several writes to the same register before a tick leave only the last written value to be committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse marking a second boundary |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The bench builds the block with its default parameters: an 8-bit address and a base year of 1970. That base is 2 modulo 4, so the leap recomputation picks out offsets 2 and 6. The 6-bit year field makes the wrap from offset 63 back to a non-leap 1970 reachable in one directed roll. Using the real base year also means the expected leap flags can be worked out by hand from calendar years.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int ADDR_W    = 8,
  parameter int YEAR_BASE = 1970
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_DATE = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFF_TIME = ADDR_W'('h14);
  localparam logic [1:0]        BASE_MOD = 2'(YEAR_BASE % 4);

  logic [5:0] sec_q, min_q;
  logic [4:0] hour_q;
  logic [4:0] day_q;
  logic [3:0] mon_q;
  logic [5:0] year_q;
  logic       leap_q;
  logic [20:0] pend_t_q;
  logic [22:0] pend_d_q;
  logic       busy_t_q, busy_d_q;

  logic [5:0] sec_n, min_n;
  logic [4:0] hour_n;
  logic [4:0] day_n;
  logic [3:0] mon_n;
  logic [5:0] year_n, year_inc;
  logic       leap_n, day_roll;

  wire wr_time = wr_en && (addr == OFF_TIME);
  wire wr_date = wr_en && (addr == OFF_DATE);

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic lp);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      4'd2:                    month_len = lp ? 5'd29 : 5'd28;
      default:                 month_len = 5'd31;
    endcase
  endfunction

  always_comb begin
    sec_n    = sec_q;
    min_n    = min_q;
    hour_n   = hour_q;
    day_roll = 1'b0;
    if (busy_t_q) begin
      sec_n  = pend_t_q[5:0];
      min_n  = pend_t_q[13:8];
      hour_n = pend_t_q[20:16];
    end else if (sec_q < 6'd59) begin
      sec_n = sec_q + 6'd1;
    end else begin
      sec_n = 6'd0;
      if (min_q < 6'd59) begin
        min_n = min_q + 6'd1;
      end else begin
        min_n = 6'd0;
        if (hour_q < 5'd23) begin
          hour_n = hour_q + 5'd1;
        end else begin
          hour_n   = 5'd0;
          day_roll = 1'b1;
        end
      end
    end
  end

  assign year_inc = year_q + 6'd1;

  always_comb begin
    day_n  = day_q;
    mon_n  = mon_q;
    year_n = year_q;
    leap_n = leap_q;
    if (busy_d_q) begin
      day_n  = pend_d_q[4:0];
      mon_n  = pend_d_q[11:8];
      year_n = pend_d_q[21:16];
      leap_n = pend_d_q[22];
    end else if (day_roll) begin
      if (day_q < month_len(mon_q, leap_q)) begin
        day_n = day_q + 5'd1;
      end else begin
        day_n = 5'd1;
        if (mon_q < 4'd12) begin
          mon_n = mon_q + 4'd1;
        end else begin
          mon_n  = 4'd1;
          year_n = year_inc;
          leap_n = ((year_inc[1:0] + BASE_MOD) == 2'd0);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q    <= '0;
      min_q    <= '0;
      hour_q   <= '0;
      day_q    <= 5'd1;
      mon_q    <= 4'd1;
      year_q   <= '0;
      leap_q   <= 1'b0;
      pend_t_q <= '0;
      pend_d_q <= '0;
      busy_t_q <= 1'b0;
      busy_d_q <= 1'b0;
    end else begin
      if (sec_tick) begin
        sec_q  <= sec_n;
        min_q  <= min_n;
        hour_q <= hour_n;
        day_q  <= day_n;
        mon_q  <= mon_n;
        year_q <= year_n;
        leap_q <= leap_n;
      end
      if (wr_time) begin
        pend_t_q <= wdata[20:0];
        busy_t_q <= 1'b1;
      end else if (sec_tick) begin
        busy_t_q <= 1'b0;
      end
      if (wr_date) begin
        pend_d_q <= wdata[22:0];
        busy_d_q <= 1'b1;
      end else if (sec_tick) begin
        busy_d_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: begin
        rdata[8] = busy_t_q;
        rdata[7] = busy_d_q;
      end
      OFF_TIME: begin
        rdata[5:0]   = sec_q;
        rdata[13:8]  = min_q;
        rdata[20:16] = hour_q;
      end
      OFF_DATE: begin
        rdata[4:0]   = day_q;
        rdata[11:8]  = mon_q;
        rdata[21:16] = year_q;
        rdata[22]    = leap_q;
      end
      default: rdata = '0;
    endcase
  end

  p_time_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> busy_t_q);

  p_date_busy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_date |=> busy_d_q);

  p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_time && !wr_date) |=> (!busy_t_q && !busy_d_q));

  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> ($stable({hour_q, min_q, sec_q}) && $stable({leap_q, year_q, mon_q, day_q})));

  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !busy_t_q && sec_q < 6'd59) |=> (sec_q == $past(sec_q) + 6'd1));

  p_no_date_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !busy_d_q && (busy_t_q || sec_q != 6'd59)) |=> $stable({leap_q, year_q, mon_q, day_q}));

endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DATE = 8'h10;
  localparam logic [7:0] A_TIME = 8'h14;

  rtc_calendar uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_time(int h, int m, int s);
    mk_time = {11'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
  endfunction

  function automatic logic [31:0] mk_date(int lp, int y, int mo, int d);
    mk_date = {9'b0, 1'(lp), 6'(y), 4'b0, 4'(mo), 3'b0, 5'(d)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_cal(logic [31:0] d, logic [31:0] t);
    wr(A_DATE, d);
    wr(A_TIME, t);
    tick();
  endtask

  task automatic expect_regs(string tag, logic [31:0] d, logic [31:0] t);
    logic [31:0] v;
    rd(A_TIME, v); chk({tag, " time"}, v, t);
    rd(A_DATE, v); chk({tag, " date"}, v, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    expect_regs("R1 reset", mk_date(0, 0, 1, 1), mk_time(0, 0, 0));
    rd(A_CTRL, v); chk("R1 reset ctrl", v, 32'h0);
    rd(8'h04, v);  chk("R2 unmapped addr", v, 32'h0);
  endtask

  task automatic t_busy_and_commit();
    logic [31:0] v;
    wr(A_TIME, mk_time(10, 20, 30));
    rd(A_CTRL, v); chk("R4 time busy bit8", v, 32'h100);
    rd(A_TIME, v); chk("R4 time unchanged before commit", v, mk_time(0, 0, 0));
    wr(A_DATE, mk_date(1, 30, 2, 28));
    rd(A_CTRL, v); chk("R5 both busy bits", v, 32'h180);
    rd(A_DATE, v); chk("R5 date unchanged before commit", v, mk_date(0, 0, 1, 1));
    tick();
    rd(A_CTRL, v); chk("R6 busy cleared", v, 32'h0);
    expect_regs("R6 commit no increment", mk_date(1, 30, 2, 28), mk_time(10, 20, 30));
    tick();
    expect_regs("R3 second step", mk_date(1, 30, 2, 28), mk_time(10, 20, 31));
  endtask

  task automatic t_time_wrap();
    set_cal(mk_date(0, 3, 5, 10), mk_time(12, 59, 59));
    tick();
    expect_regs("R3 hour carry", mk_date(0, 3, 5, 10), mk_time(13, 0, 0));
    set_cal(mk_date(0, 3, 5, 10), mk_time(7, 14, 59));
    tick();
    expect_regs("R3 minute carry", mk_date(0, 3, 5, 10), mk_time(7, 15, 0));
  endtask

  task automatic day_roll(string tag, logic [31:0] d0, logic [31:0] d1);
    set_cal(d0, mk_time(23, 59, 59));
    tick();
    expect_regs(tag, d1, mk_time(0, 0, 0));
  endtask

  task automatic t_month_lengths();
    day_roll("R8 Jan31", mk_date(1, 30, 1, 31), mk_date(1, 30, 2, 1));
    day_roll("R8 Feb28 nonleap", mk_date(0, 31, 2, 28), mk_date(0, 31, 3, 1));
    day_roll("R8 Feb28 leap", mk_date(1, 30, 2, 28), mk_date(1, 30, 2, 29));
    day_roll("R8 Feb29 leap", mk_date(1, 30, 2, 29), mk_date(1, 30, 3, 1));
    day_roll("R8 Apr30", mk_date(0, 31, 4, 30), mk_date(0, 31, 5, 1));
    day_roll("R8 Apr29 mid", mk_date(0, 31, 4, 29), mk_date(0, 31, 4, 30));
  endtask

  task automatic t_year_roll();
    day_roll("R9 1971 to 1972 leap", mk_date(0, 1, 12, 31), mk_date(1, 2, 1, 1));
    day_roll("R9 1975 to 1976 leap", mk_date(0, 5, 12, 31), mk_date(1, 6, 1, 1));
    day_roll("R9 1972 to 1973", mk_date(1, 2, 12, 31), mk_date(0, 3, 1, 1));
    day_roll("R9 offset 63 wraps", mk_date(0, 63, 12, 31), mk_date(0, 0, 1, 1));
  endtask

  task automatic t_coincident();
    logic [31:0] v;
    set_cal(mk_date(0, 3, 5, 10), mk_time(1, 2, 3));
    @(negedge clk);
    wr_en = 1'b1; addr = A_TIME; wdata = mk_time(5, 6, 7); sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    rd(A_CTRL, v); chk("R7 busy held", v, 32'h100);
    rd(A_TIME, v); chk("R7 tick counted", v, mk_time(1, 2, 4));
    tick();
    rd(A_TIME, v); chk("R7 committed next tick", v, mk_time(5, 6, 7));
  endtask

  task automatic t_last_wins();
    logic [31:0] v;
    wr(A_TIME, mk_time(3, 3, 3));
    wr(A_TIME, mk_time(4, 44, 44));
    tick();
    rd(A_TIME, v); chk("R11 last time write", v, mk_time(4, 44, 44));
  endtask

  task automatic t_coherence();
    set_cal(mk_date(0, 3, 5, 10), mk_time(23, 59, 59));
    wr(A_DATE, mk_date(0, 40, 6, 15));
    tick();
    expect_regs("R10 date pending at rollover", mk_date(0, 40, 6, 15), mk_time(0, 0, 0));
    set_cal(mk_date(0, 3, 5, 10), mk_time(23, 59, 59));
    wr(A_TIME, mk_time(8, 0, 0));
    tick();
    expect_regs("R10 time pending no carry", mk_date(0, 3, 5, 10), mk_time(8, 0, 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_and_commit();
    t_time_wrap();
    t_month_lengths();
    t_year_roll();
    t_coincident();
    t_last_wins();
    t_coherence();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule